// File: doc/BRIEF.md
# Supply-Monitor Power-On Reset Sequencer

This block turns a digitised supply comparator bit into the active-low system reset of a chip. The comparator bit is high while the divided-down supply sits above the reference. The block passes that bit through a two-flop synchroniser. It then qualifies every change with a run-length filter, so a short glitch never reaches the reset. Reset stays low while the qualified supply is low. After the supply qualifies as good, reset stays low for a programmable number of time-base ticks. That power-on delay uses the same tick as the watchdog period, so the two scale together when the tick rate changes.

A qualified brown-out pulls reset low at once, whatever the watchdog is doing. Each recovery starts the whole power-on delay again from zero. A `seq_done` flag rises together with the reset release. The watchdog uses it to ignore clear pulses until the delay has finished. A power-good signal for the logic itself returns the block to its power-up state.

Top module: `por_sequencer`

## Requirements
- R1: While `logic_pgood` is sampled low at a rising clock edge, both `sys_rst_n` and `seq_done` are 0 after that edge. The filter and the delay count are cleared, and the qualified supply starts as low.
- R2: While the qualified supply indication is low, `sys_rst_n` stays 0, including from logic power-up with `cmp_above` held low.
- R3: A run of `cmp_above` opposite to the qualified value that lasts fewer than `FILT_CYCLES` consecutive clock cycles has no effect on `sys_rst_n` or `seq_done`.
- R4: A run of `cmp_above` of at least `FILT_CYCLES` cycles changes the qualified supply. The effect on the sequence (reset forced low on a drop, delay started on a rise) becomes visible after the `FILT_CYCLES+3`-th rising edge that sampled the new level, counting the first such edge as one.
- R5: After the qualified supply rises, ticks are counted from the following cycle on. `sys_rst_n` goes to 1 on the edge that counts the `POR_TICKS`-th `base_tick` sampled high.
- R6: A qualified brown-out during the power-on delay discards the ticks counted so far. After recovery, a full `POR_TICKS` ticks are needed again.
- R7: A qualified brown-out after release drives both `sys_rst_n` and `seq_done` to 0 with the R4 latency.
- R8: `seq_done` is 1 exactly when `sys_rst_n` is 1, and it only rises on a counted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast logic clock |
| logic_pgood | input | 1 | Power-good for the logic, low returns the block to its power-up state (sampled on `clk`) |
| base_tick | input | 1 | One-cycle time-base strobe shared with the watchdog |
| cmp_above | input | 1 | Raw comparator bit, 1 when the supply is above the reference |
| sys_rst_n | output | 1 | Active-low system reset |
| seq_done | output | 1 | Power-on delay complete, gates the watchdog |

## Verification
The assertions assume that `base_tick` is a single-cycle strobe synchronous to `clk`. They also assume that `logic_pgood` stays low for at least one rising edge whenever it drops, and they take `cmp_above` as arbitrary, since it is asynchronous. The stimulus drives all inputs on the falling clock edge. It generates the tick as a one-cycle pulse every four clocks and holds the power-good low for several cycles each time. It moves the comparator bit in runs of chosen lengths: glitches one cycle short of the filter length, exactly qualifying drops, and drops in the middle of the delay. A behavioural model in the bench tracks the synchroniser delay, the run length and the tick count, and the bench compares both outputs against it on every clock.

// File: rtl/por_pkg.sv
// Package por_pkg
// Shared types for the power-on reset sequencer.
// Assumes nothing beyond being compiled before the modules that use it.
package por_pkg;

    // Sequencer states: holding in reset, counting the delay, released.
    typedef enum logic [1:0] {
        SEQ_HOLD = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/por_sync.sv
// Module por_sync
// Multi-flop synchroniser that brings the asynchronous comparator bit into
// the clk domain. Assumes the input may change at any time; the output is
// the input delayed by STAGES clock edges and cleared by the logic reset.
module por_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw bit through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];

    initial begin
        assert (STAGES >= 2) else $error("por_sync needs at least two stages");
    end

endmodule

// File: rtl/por_filter.sv
// Module por_filter
// Run-length qualifier for the synchronised comparator bit. The qualified
// level changes only after the input has disagreed with it for FILT_CYCLES
// consecutive clocks; any agreeing cycle restarts the run. Assumes a
// synchronous input. After reset the qualified level is low (supply bad).
module por_filter #(
    parameter int FILT_CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);

    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    logic          level_q;
    logic [CW-1:0] run_q;

    // Count disagreeing cycles and flip the qualified level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            run_q   <= '0;
        end else if (din == level_q) begin
            run_q   <= '0;
        end else if (run_q == LAST) begin
            level_q <= din;
            run_q   <= '0;
        end else begin
            run_q   <= run_q + 1'b1;
        end
    end

    assign level = level_q;

    // A flip of the qualified level must follow the sampled input (R3).
    p_flip_follows_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> ($past(din) == level_q));

    // The run counter never reaches the filter length (R4).
    p_run_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < CW'(FILT_CYCLES));

endmodule

// File: rtl/por_delay.sv
// Module por_delay
// Power-on delay sequencer. Holds reset while the qualified supply is low,
// counts POR_TICKS time-base ticks once it is good, then releases. A low
// supply in any state returns it to HOLD at once and discards the count.
// Assumes tick is a one-cycle strobe synchronous to clk.
module por_delay
    import por_pkg::*;
#(
    parameter int POR_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic tick,
    output logic done
);

    localparam int CW = $clog2(POR_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(POR_TICKS - 1);

    seq_state_t    state_q;
    logic [CW-1:0] tcnt_q;

    // Advance the hold / count / release sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_HOLD;
            tcnt_q  <= '0;
        end else if (!supply_ok) begin
            state_q <= SEQ_HOLD;
            tcnt_q  <= '0;
        end else begin
            unique case (state_q)
                SEQ_HOLD: begin
                    state_q <= SEQ_WAIT;
                    tcnt_q  <= '0;
                end
                SEQ_WAIT: begin
                    if (tick) begin
                        if (tcnt_q == LAST) begin
                            state_q <= SEQ_DONE;
                            tcnt_q  <= '0;
                        end else begin
                            tcnt_q  <= tcnt_q + 1'b1;
                        end
                    end
                end
                SEQ_DONE: begin
                    state_q <= SEQ_DONE;
                end
                default: begin
                    state_q <= SEQ_HOLD;
                    tcnt_q  <= '0;
                end
            endcase
        end
    end

    assign done = (state_q == SEQ_DONE);

    // A bad supply always lands the sequencer in HOLD next cycle (R7).
    p_brownout_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (state_q == SEQ_HOLD));

    // Release only comes from WAIT on a tick (R5).
    p_release_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(tick) && $past(state_q) == SEQ_WAIT));

    // The tick count stays inside the delay length (R6).
    p_count_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tcnt_q < CW'(POR_TICKS));

endmodule

// File: rtl/por_sequencer.sv
// Module por_sequencer
// Top of the power-on reset sequencer: synchroniser, run-length filter and
// tick-based delay in series. Assumes base_tick is the watchdog time base
// and logic_pgood is held low for at least one clock edge when asserted.
module por_sequencer #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 250,
    parameter int POR_TICKS   = 100
) (
    input  logic clk,
    input  logic logic_pgood,
    input  logic base_tick,
    input  logic cmp_above,
    output logic sys_rst_n,
    output logic seq_done
);

    logic cmp_sync;
    logic supply_ok;
    logic delay_done;

    por_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (logic_pgood),
        .din   (cmp_above),
        .dout  (cmp_sync)
    );

    por_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filter (
        .clk   (clk),
        .rst_n (logic_pgood),
        .din   (cmp_sync),
        .level (supply_ok)
    );

    por_delay #(.POR_TICKS(POR_TICKS)) u_delay (
        .clk       (clk),
        .rst_n     (logic_pgood),
        .supply_ok (supply_ok),
        .tick      (base_tick),
        .done      (delay_done)
    );

    assign sys_rst_n = delay_done;
    assign seq_done  = delay_done;

    // Logic power loss forces reset low on the next cycle (R1).
    p_unpowered_in_reset_r1: assert property (@(posedge clk)
        !logic_pgood |=> (!sys_rst_n && !seq_done));

    // Reset may only be released while the qualified supply was good (R2).
    p_release_needs_supply_r2: assert property (@(posedge clk) disable iff (!logic_pgood)
        sys_rst_n |-> $past(supply_ok));

endmodule

// File: tb/tb_por_sequencer.sv
module tb_por_sequencer;

    localparam int FILT = 8;
    localparam int PORT = 10;
    localparam int TDIV = 4;

    logic clk = 1'b0;
    logic logic_pgood = 1'b0;
    logic base_tick = 1'b0;
    logic cmp_above = 1'b0;
    logic sys_rst_n;
    logic seq_done;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    string cur_req = "R1";

    por_sequencer #(.SYNC_STAGES(2), .FILT_CYCLES(FILT), .POR_TICKS(PORT)) dut (
        .clk(clk), .logic_pgood(logic_pgood), .base_tick(base_tick),
        .cmp_above(cmp_above), .sys_rst_n(sys_rst_n), .seq_done(seq_done)
    );

    always #10 clk = ~clk;

    // Tick strobe every TDIV clocks, driven on the falling edge.
    int tdiv_cnt = 0;
    always @(negedge clk) begin
        tdiv_cnt  <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
        base_tick <= (tdiv_cnt == TDIV - 1);
    end

    // Behavioural reference: delayed samples, disagreement run, tick count.
    bit m_hist[$];
    bit m_good = 0;
    int m_run = 0;
    int m_phase = 0;
    int m_ticks = 0;
    always @(posedge clk) begin
        if (!logic_pgood) begin
            m_hist = {};
            m_hist.push_back(1'b0); m_hist.push_back(1'b0);
            m_good = 0; m_run = 0; m_phase = 0; m_ticks = 0;
        end else begin
            bit seen;
            if (!m_good) begin
                m_phase = 0; m_ticks = 0;
            end else if (m_phase == 0) begin
                m_phase = 1; m_ticks = 0;
            end else if (m_phase == 1 && base_tick) begin
                m_ticks++;
                if (m_ticks == PORT) m_phase = 2;
            end
            seen = m_hist[0];
            if (seen != m_good) begin
                m_run++;
                if (m_run == FILT) begin m_good = seen; m_run = 0; end
            end else begin
                m_run = 0;
            end
            void'(m_hist.pop_front());
            m_hist.push_back(cmp_above);
        end
    end

    // Compare every clock away from the active edge.
    always @(negedge clk) begin
        bit exp;
        exp = (m_phase == 2);
        checks++;
        if (sys_rst_n !== exp || seq_done !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: sys_rst_n=%b seq_done=%b expected %b",
                     cur_req, cyc, sys_rst_n, seq_done, exp);
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s directed: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: power-up of the logic
        cur_req = "R1";
        wait_cyc(5);
        chk("R1", sys_rst_n, 1'b0);
        chk("R1", seq_done, 1'b0);
        logic_pgood = 1'b1;

        // R2: comparator low, reset must stay low despite ticks
        cur_req = "R2";
        wait_cyc(60);
        chk("R2", sys_rst_n, 1'b0);

        // R5 / R4: supply rises, delay runs out
        cur_req = "R5";
        cmp_above = 1'b1;
        wait_cyc(FILT + 3 + 20);
        chk("R5", sys_rst_n, 1'b0);
        wait_cyc(40);
        chk("R5", sys_rst_n, 1'b1);
        chk("R8", seq_done, 1'b1);

        // R3: glitches one cycle short of qualification
        cur_req = "R3";
        for (int len = 1; len < FILT; len++) begin
            cmp_above = 1'b0;
            wait_cyc(len);
            cmp_above = 1'b1;
            wait_cyc(6);
        end
        wait_cyc(6);
        chk("R3", sys_rst_n, 1'b1);

        // R4 / R7: qualifying drop after release
        cur_req = "R7";
        cmp_above = 1'b0;
        wait_cyc(FILT + 2);
        chk("R4", sys_rst_n, 1'b1);
        wait_cyc(1);
        chk("R7", sys_rst_n, 1'b0);
        chk("R7", seq_done, 1'b0);
        wait_cyc(4);

        // R6: drop in the middle of the delay restarts it
        cur_req = "R6";
        cmp_above = 1'b1;
        wait_cyc(25);
        cmp_above = 1'b0;
        wait_cyc(12);
        cmp_above = 1'b1;
        wait_cyc(41);
        chk("R6", sys_rst_n, 1'b0);
        wait_cyc(30);
        chk("R6", sys_rst_n, 1'b1);

        // R1: logic power loss while released
        cur_req = "R1";
        logic_pgood = 1'b0;
        wait_cyc(1);
        chk("R1", sys_rst_n, 1'b0);
        chk("R1", seq_done, 1'b0);
        wait_cyc(3);
        logic_pgood = 1'b1;
        cur_req = "R4";
        wait_cyc(FILT + 2 + 45);
        chk("R4", sys_rst_n, 1'b1);
        wait_cyc(3);
        finish_run();
    end

endmodule